// File: doc/BRIEF.md
# Drowsy Memory Bank Controller

This block sits in front of a banked synchronous SRAM and chooses the supply level of each bank. When a bank is not being used it holds a low retention level, which keeps its contents but cannot be read or written. Only the bank that a request addresses is raised to full level. The bank is decoded from the request address in the cycle the request is accepted. The bank's level therefore changes on that same edge, one stage before the array is touched. As a result the read or write never waits for a supply change, and latency and throughput are the same as for an always-on memory.

Each bank reports its level on a two-bit mode field. The bank that performs the current access shows read or write. A bank that was used recently and has not timed out shows an awake-idle state. Every other bank shows retention. The `idle_limit` input sets how long a bank stays awake after its last access. Another access to the same bank within that window restarts the count.

The request side is valid/ready. `req_ready` is low while reset is asserted and high from the first clock edge after reset is released. After that the block never applies back-pressure and accepts one request in every cycle. Read responses carry no ready signal, so the consumer must take `rsp_valid`/`rsp_rdata` in the cycle it is shown.

Top module: `drowsy_bank_ctrl`

## Requirements
- R1: While reset is asserted and in the first cycle after it is released, every bank mode is retention (0), `bank_awake` is 0, `rsp_valid` is 0 and `req_ready` is 0.
- R2: A bank mode is 2 bits, with bank b at `bank_mode[2b+1:2b]`. The encodings are 0 retention, 1 read, 2 write and 3 awake-idle. `bank_awake[b]` is 1 exactly when that mode is not 0. No more than one bank is in read or write in any cycle.
- R3: With INTERLEAVE=0 the bank index is the top log2(NBANK) address bits; with INTERLEAVE=1 it is the low bits. In the cycle after a request is accepted, the addressed bank shows read (1) or write (2), matching `req_write`.
- R4: When a read is accepted at edge E, `rsp_valid` is high for one cycle after edge E+1. In that cycle `rsp_rdata` holds the last data written to that address. An accepted write produces no response.
- R5: After reset `req_ready` stays at 1. A request presented in every cycle is accepted in every cycle, and back-to-back requests to different banks or to the same address see no stall. A read that follows a write to the same address sees the new data.
- R6: When a bank has no further access, it shows awake-idle (3) for `idle_limit` cycles after its read/write cycle and then returns to retention (0).
- R7: An access to a bank that is still awake restarts its idle window from that access.
- R8: Back-to-back accesses to two different banks with `idle_limit` ≥ 1 leave both banks awake in the cycle after the second acceptance. With `idle_limit` = 0, only the second bank is awake in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| idle_limit | input | IDLE_W | Cycles a bank stays awake-idle after its last access |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | Read data present (one cycle) |
| rsp_rdata | output | DATA_W | Read data |
| bank_awake | output | NBANK | Per-bank supply select, 1 = full level |
| bank_mode | output | 2*NBANK | Per-bank level state, 2 bits each |

## Verification
Two things can land in the same cycle: the idle countdown of one bank and the wake-up of a different bank. They meet when two requests to different banks are issued on consecutive edges. The bench runs this pair with a window of three cycles and expects two awake banks, one in awake-idle and one in read. It then runs the same pair with a window of zero and expects only the new bank awake. A second collision is a read issued right behind a write to the same address, which is judged by the data returned one cycle later.

// File: rtl/drowsy_pkg.sv
package drowsy_pkg;
  typedef enum logic [1:0] {
    LVL_RET  = 2'd0,
    LVL_RD   = 2'd1,
    LVL_WR   = 2'd2,
    LVL_HOLD = 2'd3
  } lvl_e;
endpackage

// File: rtl/drowsy_bank_decode.sv
module drowsy_bank_decode #(
  parameter int ADDR_W     = 6,
  parameter int NBANK      = 4,
  parameter bit INTERLEAVE = 1'b0,
  localparam int BANK_W    = $clog2(NBANK),
  localparam int ROW_W     = ADDR_W - BANK_W
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [BANK_W-1:0] bank,
  output logic [ROW_W-1:0]  row,
  output logic [NBANK-1:0]  onehot
);
  generate
    if (INTERLEAVE) begin : g_low
      assign bank = addr[BANK_W-1:0];
      assign row  = addr[ADDR_W-1:BANK_W];
    end else begin : g_high
      assign bank = addr[ADDR_W-1:ROW_W];
      assign row  = addr[ROW_W-1:0];
    end
  endgenerate

  always_comb begin
    onehot = '0;
    onehot[bank] = 1'b1;
  end
endmodule

// File: rtl/drowsy_bank_pwr.sv
module drowsy_bank_pwr
  import drowsy_pkg::*;
#(
  parameter int IDLE_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hit,
  input  logic              hit_write,
  input  logic [IDLE_W-1:0] idle_limit,
  output lvl_e              mode
);
  logic [IDLE_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode  <= LVL_RET;
      cnt_q <= '0;
    end else if (hit) begin
      mode  <= hit_write ? LVL_WR : LVL_RD;
      cnt_q <= '0;
    end else if (mode != LVL_RET) begin
      if (cnt_q >= idle_limit) begin
        mode  <= LVL_RET;
        cnt_q <= '0;
      end else begin
        mode  <= LVL_HOLD;
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/drowsy_bank_array.sv
module drowsy_bank_array #(
  parameter int NBANK  = 4,
  parameter int ROW_W  = 4,
  parameter int DATA_W = 16,
  localparam int BANK_W = $clog2(NBANK),
  localparam int DEPTH  = NBANK << ROW_W
) (
  input  logic              clk,
  input  logic              en,
  input  logic              we,
  input  logic [BANK_W-1:0] bank,
  input  logic [ROW_W-1:0]  row,
  input  logic [DATA_W-1:0] wdata,
  input  logic [NBANK-1:0]  powered,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [DEPTH];
  logic              live;

  // A bank at retention level can hold data but not be sensed or written.
  assign live = en && powered[bank];

  always_ff @(posedge clk) begin
    if (live && we) mem[{bank, row}] <= wdata;
    if (live && !we) rdata <= mem[{bank, row}];
    else if (en && !we) rdata <= '0;
  end
endmodule

// File: rtl/drowsy_bank_ctrl.sv
module drowsy_bank_ctrl
  import drowsy_pkg::*;
#(
  parameter int ADDR_W     = 6,
  parameter int DATA_W     = 16,
  parameter int NBANK      = 4,
  parameter int IDLE_W     = 4,
  parameter bit INTERLEAVE = 1'b0
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [IDLE_W-1:0]    idle_limit,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic                 req_write,
  input  logic [ADDR_W-1:0]    req_addr,
  input  logic [DATA_W-1:0]    req_wdata,
  output logic                 rsp_valid,
  output logic [DATA_W-1:0]    rsp_rdata,
  output logic [NBANK-1:0]     bank_awake,
  output logic [2*NBANK-1:0]   bank_mode
);
  localparam int BANK_W = $clog2(NBANK);
  localparam int ROW_W  = ADDR_W - BANK_W;

  logic [BANK_W-1:0] dec_bank;
  logic [ROW_W-1:0]  dec_row;
  logic [NBANK-1:0]  dec_onehot;
  logic              accept;

  logic              s1_valid, s1_write;
  logic [BANK_W-1:0] s1_bank;
  logic [ROW_W-1:0]  s1_row;
  logic [DATA_W-1:0] s1_wdata;
  lvl_e              mode_q [NBANK];

  assign accept = req_valid && req_ready;

  drowsy_bank_decode #(
    .ADDR_W(ADDR_W), .NBANK(NBANK), .INTERLEAVE(INTERLEAVE)
  ) u_dec (
    .addr(req_addr), .bank(dec_bank), .row(dec_row), .onehot(dec_onehot)
  );

  generate
    for (genvar b = 0; b < NBANK; b++) begin : g_bank
      drowsy_bank_pwr #(.IDLE_W(IDLE_W)) u_pwr (
        .clk(clk), .rst_n(rst_n),
        .hit(accept && dec_onehot[b]), .hit_write(req_write),
        .idle_limit(idle_limit), .mode(mode_q[b])
      );
      assign bank_mode[2*b +: 2] = mode_q[b];
      assign bank_awake[b]       = (mode_q[b] != LVL_RET);
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_ready <= 1'b0;
      s1_valid  <= 1'b0;
      s1_write  <= 1'b0;
      s1_bank   <= '0;
      s1_row    <= '0;
      s1_wdata  <= '0;
      rsp_valid <= 1'b0;
    end else begin
      req_ready <= 1'b1;
      s1_valid  <= accept;
      s1_write  <= req_write;
      s1_bank   <= dec_bank;
      s1_row    <= dec_row;
      s1_wdata  <= req_wdata;
      rsp_valid <= s1_valid && !s1_write;
    end
  end

  drowsy_bank_array #(
    .NBANK(NBANK), .ROW_W(ROW_W), .DATA_W(DATA_W)
  ) u_arr (
    .clk(clk), .en(s1_valid), .we(s1_write), .bank(s1_bank), .row(s1_row),
    .wdata(s1_wdata), .powered(bank_awake), .rdata(rsp_rdata)
  );
endmodule

// File: rtl/drowsy_bank_ctrl_chk.sv
module drowsy_bank_ctrl_chk #(
  parameter int NBANK  = 4,
  localparam int BANK_W = $clog2(NBANK)
) (
  input logic               clk,
  input logic               rst_n,
  input logic               req_valid,
  input logic               req_ready,
  input logic               req_write,
  input logic               rsp_valid,
  input logic [NBANK-1:0]   bank_awake,
  input logic [2*NBANK-1:0] bank_mode,
  input logic               s1_valid,
  input logic               s1_write,
  input logic [BANK_W-1:0]  s1_bank
);
  logic             rst_q;
  logic [NBANK-1:0] active;

  always_comb begin
    for (int b = 0; b < NBANK; b++)
      active[b] = (bank_mode[2*b +: 2] == 2'd1) || (bank_mode[2*b +: 2] == 2'd2);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_q <= 1'b0;
    else        rst_q <= 1'b1;
  end

  // R1: first edge after reset release still sees every bank in retention
  always_ff @(posedge clk) begin
    if (rst_n && !rst_q) begin
      a_r1_reset_retention: assert (bank_awake == '0 && bank_mode == '0 && !rsp_valid);
    end
  end

  a_r2_one_active: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(active) <= 1);

  a_r3_awake_for_access: assert property (@(posedge clk) disable iff (!rst_n)
    s1_valid |-> bank_awake[s1_bank]);

  a_r3_mode_kind: assert property (@(posedge clk) disable iff (!rst_n)
    s1_valid |-> bank_mode[2*s1_bank +: 2] == (s1_write ? 2'd2 : 2'd1));

  a_r4_read_response: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !req_write) |=> ##1 rsp_valid);

  a_r4_no_write_response: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_write) |=> ##1 !rsp_valid);

  a_r5_ready_held: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |=> req_ready);
endmodule

bind drowsy_bank_ctrl drowsy_bank_ctrl_chk #(.NBANK(NBANK)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_write(req_write), .rsp_valid(rsp_valid), .bank_awake(bank_awake),
  .bank_mode(bank_mode), .s1_valid(s1_valid), .s1_write(s1_write),
  .s1_bank(s1_bank)
);

// File: tb/drowsy_bank_ctrl_tb.sv
module drowsy_bank_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  idle_limit = 4'd0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [5:0]  req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic        req_ready, rsp_valid;
  logic [15:0] rsp_rdata;
  logic [3:0]  bank_awake;
  logic [7:0]  bank_mode;

  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  drowsy_bank_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .idle_limit(idle_limit),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata), .bank_awake(bank_awake), .bank_mode(bank_mode)
  );

  // {write, addr, wdata, expected read data}
  localparam logic [38:0] VEC [8] = '{
    {1'b1, 6'h05, 16'hA5A5, 16'h0000},
    {1'b1, 6'h17, 16'h1234, 16'h0000},
    {1'b1, 6'h2A, 16'hBEEF, 16'h0000},
    {1'b1, 6'h3F, 16'h0F0F, 16'h0000},
    {1'b0, 6'h05, 16'h0000, 16'hA5A5},
    {1'b0, 6'h2A, 16'h0000, 16'hBEEF},
    {1'b0, 6'h3F, 16'h0000, 16'h0F0F},
    {1'b0, 6'h17, 16'h0000, 16'h1234}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [1:0] mode_of(input int b);
    return bank_mode[2*b +: 2];
  endfunction

  task automatic put(input logic we, input logic [5:0] a, input logic [15:0] d);
    req_valid = 1'b1; req_write = we; req_addr = a; req_wdata = d;
  endtask

  task automatic settle();
    req_valid = 1'b0;
    repeat (20) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    chk("R1 mode in reset", {24'd0, bank_mode}, 32'd0);
    chk("R1 rsp_valid in reset", {31'd0, rsp_valid}, 32'd0);
    chk("R1 ready in reset", {31'd0, req_ready}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R5 ready after release", {31'd0, req_ready}, 32'd1);
    chk("R1 awake after release", {28'd0, bank_awake}, 32'd0);

    // R3 R4 R2: table walk with idle_limit 0
    for (int i = 0; i < 8; i++) begin
      logic        we;
      logic [5:0]  a;
      logic [15:0] d, e;
      {we, a, d, e} = VEC[i];
      put(we, a, d);
      @(negedge clk);
      req_valid = 1'b0;
      chk("R3 bank mode at access", {30'd0, mode_of(int'(a[5:4]))}, we ? 32'd2 : 32'd1);
      chk("R2 single awake bank", {28'd0, bank_awake}, 32'd1 << a[5:4]);
      @(negedge clk);
      chk("R4 rsp_valid", {31'd0, rsp_valid}, {31'd0, !we});
      if (!we) chk("R4 read data", {16'd0, rsp_rdata}, {16'd0, e});
      @(negedge clk);
      chk("R6 zero window back to retention", {28'd0, bank_awake}, 32'd0);
    end

    // R5: back-to-back write then reads, no stall
    put(1'b1, 6'h09, 16'h5555);
    @(negedge clk);
    chk("R5 ready held", {31'd0, req_ready}, 32'd1);
    put(1'b0, 6'h09, 16'h0000);
    @(negedge clk);
    chk("R4 no response for write", {31'd0, rsp_valid}, 32'd0);
    put(1'b0, 6'h3F, 16'h0000);
    @(negedge clk);
    req_valid = 1'b0;
    chk("R5 read after write valid", {31'd0, rsp_valid}, 32'd1);
    chk("R5 read after write data", {16'd0, rsp_rdata}, 32'h5555);
    @(negedge clk);
    chk("R5 second read valid", {31'd0, rsp_valid}, 32'd1);
    chk("R5 second read data", {16'd0, rsp_rdata}, 32'h0F0F);
    @(negedge clk);
    chk("R4 single cycle pulse", {31'd0, rsp_valid}, 32'd0);
    settle();

    // R6: window of 3
    idle_limit = 4'd3;
    @(negedge clk);
    put(1'b0, 6'h2A, 16'h0000);
    @(negedge clk);
    req_valid = 1'b0;
    chk("R6 read mode", {30'd0, mode_of(2)}, 32'd1);
    repeat (3) @(negedge clk);
    chk("R6 awake-idle at last cycle", {30'd0, mode_of(2)}, 32'd3);
    @(negedge clk);
    chk("R6 retention after window", {30'd0, mode_of(2)}, 32'd0);
    settle();

    // R7: second access within the window restarts it
    put(1'b0, 6'h17, 16'h0000);
    @(negedge clk);
    req_valid = 1'b0;
    @(negedge clk);
    put(1'b0, 6'h17, 16'h0000);
    @(negedge clk);
    req_valid = 1'b0;
    chk("R7 read mode on re-access", {30'd0, mode_of(1)}, 32'd1);
    repeat (2) @(negedge clk);
    chk("R7 still awake past first window", {30'd0, mode_of(1)}, 32'd3);
    @(negedge clk);
    chk("R7 last awake cycle", {30'd0, mode_of(1)}, 32'd3);
    @(negedge clk);
    chk("R7 retention after restarted window", {30'd0, mode_of(1)}, 32'd0);
    settle();

    // R8: two banks awake in one cycle
    put(1'b1, 6'h00, 16'h1111);
    @(negedge clk);
    put(1'b0, 6'h3F, 16'h0000);
    @(negedge clk);
    req_valid = 1'b0;
    chk("R8 two banks awake", {28'd0, bank_awake}, 32'h9);
    chk("R8 first bank idle", {30'd0, mode_of(0)}, 32'd3);
    chk("R8 second bank read", {30'd0, mode_of(3)}, 32'd1);
    settle();

    idle_limit = 4'd0;
    @(negedge clk);
    put(1'b1, 6'h00, 16'h2222);
    @(negedge clk);
    put(1'b0, 6'h3F, 16'h0000);
    @(negedge clk);
    req_valid = 1'b0;
    chk("R8 zero window one bank awake", {28'd0, bank_awake}, 32'h8);
    @(negedge clk);
    chk("R4 data with zero window", {16'd0, rsp_rdata}, 32'h0F0F);
    settle();

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule